// File: doc/BRIEF.md
# DMA Channel Scheduler with Flow Gating

This block chooses which DMA channel the transfer engine serves next. Each channel has a configuration word. That word enables or halts the channel, sets its flow type, and picks one source and one destination peripheral request line. The block merges the single-request and burst-request vectors into one request vector. From that vector and each channel's flow type it works out which channels are ready. It then grants the lowest-numbered ready channel.

A grant is shown as a valid flag plus a channel index. The grant stays fixed until the engine returns a one-cycle done pulse. The block then drops the grant for one cycle and scans again from channel 0. A channel that stays ready is therefore granted again before any higher-numbered channel. Flow types 4 to 7 are not supported. A channel set to one of them is never granted, and it raises a single-cycle error pulse.

Top module: `dma_chan_sched`

## Requirements
- R1: A channel is eligible only when its configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R2: While the global enable input is 0, no new grant is issued.
- R3: The configuration fields sit at fixed bits. Bits 13:11 hold the flow type, bits 5:1 select the source request line and bits 10:6 select the destination request line. A request line counts as asserted when it is set in either the single-request or the burst-request input.
- R4: An eligible channel is ready according to its flow type. Type 0 is always ready. Type 1 needs its destination line, type 2 needs its source line and type 3 needs both lines.
- R5: When no grant is outstanding and at least one channel is ready, the lowest-indexed ready channel is granted. The grant appears on the clock edge that ends the scan cycle.
- R6: An issued grant keeps the same index until a done pulse arrives, whatever the inputs do. A done pulse while no grant is outstanding has no effect.
- R7: A done pulse removes the grant on the next edge. The following cycle scans again from channel 0, so a channel that is still ready is granted again ahead of higher-numbered channels.
- R8: A channel with flow type 4 to 7 is never granted. When such a channel becomes eligible, its bit of the error output pulses high for exactly one cycle. The pulse happens once per eligible period, whatever the global enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable for issuing grants |
| chan_cfg | input | NUM_CH*32 | Per-channel configuration words, channel i at bits 32*i+31:32*i |
| req_single | input | NUM_REQ | Single-transfer peripheral request lines |
| req_burst | input | NUM_REQ | Burst peripheral request lines |
| xfer_done | input | 1 | One-cycle pulse from the engine ending the current element |
| grant_valid | output | 1 | A grant is outstanding |
| grant_idx | output | $clog2(NUM_CH) | Index of the granted channel |
| flow_err | output | NUM_CH | One-cycle pulse per channel configured with an unsupported flow type |

## Verification
Two things can happen in the same cycle. A done pulse can arrive while no grant is outstanding, in the very cycle a scan finds a ready channel. The bench drives both at one falling edge and expects the grant to be issued normally, because the stray done pulse must not cancel or delay it. A second pair is a done pulse arriving while a lower-numbered channel has just become ready. The bench judges that case by checking that the regrant after the one-cycle gap goes to the lower channel rather than to the one that just finished.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int CFG_W     = 32;
  localparam int SEL_W     = 5;
  localparam int BIT_EN    = 0;
  localparam int SRC_LSB   = 1;
  localparam int DST_LSB   = 6;
  localparam int FLOW_LSB  = 11;
  localparam int BIT_HALT  = 18;

  typedef enum logic [2:0] {
    FLOW_FREE = 3'd0,
    FLOW_DST  = 3'd1,
    FLOW_SRC  = 3'd2,
    FLOW_BOTH = 3'd3
  } flow_e;
endpackage

// File: rtl/dma_ready_eval.sv
module dma_ready_eval
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_REQ = 32
) (
  input  logic [NUM_CH*CFG_W-1:0] cfg_flat,
  input  logic [NUM_REQ-1:0]      req_any,
  output logic [NUM_CH-1:0]       ready,
  output logic [NUM_CH-1:0]       bad_flow
);
  logic [(1<<SEL_W)-1:0] req_ext;
  assign req_ext = (1<<SEL_W)'(req_any);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CFG_W-1:0] word;
    logic             elig;
    logic [2:0]       ftype;
    logic             src_hit;
    logic             dst_hit;

    assign word    = cfg_flat[c*CFG_W +: CFG_W];
    assign elig    = word[BIT_EN] & ~word[BIT_HALT];
    assign ftype   = word[FLOW_LSB +: 3];
    assign src_hit = req_ext[word[SRC_LSB +: SEL_W]];
    assign dst_hit = req_ext[word[DST_LSB +: SEL_W]];

    always_comb begin
      ready[c]    = 1'b0;
      bad_flow[c] = elig & ftype[2];
      if (elig) begin
        case (ftype)
          FLOW_FREE: ready[c] = 1'b1;
          FLOW_DST:  ready[c] = dst_hit;
          FLOW_SRC:  ready[c] = src_hit;
          FLOW_BOTH: ready[c] = src_hit & dst_hit;
          default:   ready[c] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] cand,
  output logic              found,
  output logic [IDX_W-1:0]  pick
);
  always_comb begin
    found = |cand;
    pick  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) pick = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_flow_err.sv
module dma_flow_err #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] bad_flow,
  output logic [NUM_CH-1:0] err_pulse
);
  logic [NUM_CH-1:0] seen_q, seen_d;
  logic [NUM_CH-1:0] pulse_q, pulse_d;

  always_comb begin
    seen_d  = bad_flow;
    pulse_d = bad_flow & ~seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      pulse_q <= '0;
    end else begin
      seen_q  <= seen_d;
      pulse_q <= pulse_d;
    end
  end

  assign err_pulse = pulse_q;
endmodule

// File: rtl/dma_chan_sched.sv
module dma_chan_sched
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_REQ = 32,
  localparam int IDX_W  = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic [NUM_CH*CFG_W-1:0] chan_cfg,
  input  logic [NUM_REQ-1:0]      req_single,
  input  logic [NUM_REQ-1:0]      req_burst,
  input  logic                    xfer_done,
  output logic                    grant_valid,
  output logic [IDX_W-1:0]        grant_idx,
  output logic [NUM_CH-1:0]       flow_err
);
  logic [NUM_REQ-1:0] req_any;
  logic [NUM_CH-1:0]  ready;
  logic [NUM_CH-1:0]  bad_flow;
  logic               found;
  logic [IDX_W-1:0]   pick;

  logic               valid_q, valid_d;
  logic [IDX_W-1:0]   idx_q;
  logic               idx_en;

  assign req_any = req_single | req_burst;

  dma_ready_eval #(.NUM_CH(NUM_CH), .NUM_REQ(NUM_REQ)) u_ready (
    .cfg_flat (chan_cfg),
    .req_any  (req_any),
    .ready    (ready),
    .bad_flow (bad_flow)
  );

  dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .cand  (ready),
    .found (found),
    .pick  (pick)
  );

  dma_flow_err #(.NUM_CH(NUM_CH)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .bad_flow  (bad_flow),
    .err_pulse (flow_err)
  );

  always_comb begin
    idx_en  = ~valid_q & glb_en & found;
    valid_d = valid_q;
    if (valid_q) begin
      if (xfer_done) valid_d = 1'b0;
    end else if (idx_en) begin
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= pick;
    end
  end

  assign grant_valid = valid_q;
  assign grant_idx   = idx_q;
endmodule

// File: rtl/dma_chan_sched_chk.sv
module dma_chan_sched_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_REQ = 32,
  localparam int IDX_W  = $clog2(NUM_CH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 glb_en,
  input logic [NUM_CH*32-1:0] chan_cfg,
  input logic                 xfer_done,
  input logic                 grant_valid,
  input logic [IDX_W-1:0]     grant_idx,
  input logic [NUM_CH-1:0]    flow_err
);
  logic [NUM_CH-1:0] elig, unsup, elig_q, unsup_q;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      elig[i]  = chan_cfg[32*i] & ~chan_cfg[32*i+18];
      unsup[i] = chan_cfg[32*i+13];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_q  <= '0;
      unsup_q <= '0;
    end else begin
      elig_q  <= elig;
      unsup_q <= unsup;
    end
  end

  a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> elig_q[grant_idx]);

  a_r2_no_grant_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && !glb_en) |=> !grant_valid);

  a_r6_grant_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !xfer_done) |=> (grant_valid && $stable(grant_idx)));

  a_r7_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && xfer_done) |=> !grant_valid);

  a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|flow_err) |=> ((flow_err & $past(flow_err)) == '0));

  a_r8_never_granted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> !unsup_q[grant_idx]);
endmodule

bind dma_chan_sched dma_chan_sched_chk #(.NUM_CH(NUM_CH), .NUM_REQ(NUM_REQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_en      (glb_en),
  .chan_cfg    (chan_cfg),
  .xfer_done   (xfer_done),
  .grant_valid (grant_valid),
  .grant_idx   (grant_idx),
  .flow_err    (flow_err)
);

// File: tb/tb_dma_chan_sched.sv
module tb_dma_chan_sched;
  localparam int NCH  = 8;
  localparam int NREQ = 32;

  logic               clk;
  logic               rst_n;
  logic               glb_en;
  logic [NCH*32-1:0]  chan_cfg;
  logic [NREQ-1:0]    req_single;
  logic [NREQ-1:0]    req_burst;
  logic               xfer_done;
  logic               grant_valid;
  logic [2:0]         grant_idx;
  logic [NCH-1:0]     flow_err;

  int total = 0;
  int bad   = 0;

  dma_chan_sched #(.NUM_CH(NCH), .NUM_REQ(NREQ)) dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .chan_cfg(chan_cfg),
    .req_single(req_single), .req_burst(req_burst), .xfer_done(xfer_done),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .flow_err(flow_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic en, input logic halt, input int flow,
                                     input int src, input int dst);
    logic [31:0] w = '0;
    w[0]     = en;
    w[18]    = halt;
    w[13:11] = 3'(flow);
    w[5:1]   = 5'(src);
    w[10:6]  = 5'(dst);
    return w;
  endfunction

  function automatic logic rdy(input logic [31:0] w, input logic [31:0] r);
    logic s = r[w[5:1]];
    logic d = r[w[10:6]];
    if (!(w[0] && !w[18])) return 1'b0;
    case (w[13:11])
      3'd0: return 1'b1;
      3'd1: return d;
      3'd2: return s;
      3'd3: return s && d;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_pick(input logic [NCH*32-1:0] cf, input logic [31:0] r);
    for (int i = 0; i < NCH; i++) begin
      if (rdy(cf[32*i +: 32], r)) return i;
    end
    return -1;
  endfunction

  task automatic finish_grant(input string tag);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk(grant_valid == 1'b0, tag, int'(grant_valid), 0);
  endtask

  initial begin
    glb_en = 0; chan_cfg = '0; req_single = '0; req_burst = '0; xfer_done = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(grant_valid == 0 && flow_err == 0, "reset", int'(grant_valid), 0);
    rst_n = 1;
    step();

    // R8: unsupported flow type pulses once, never granted
    glb_en = 1;
    chan_cfg[32*2 +: 32] = mk(1, 0, 6, 0, 0);
    step();
    chk(flow_err == 8'b0000_0100, "R8 pulse", int'(flow_err), 4);
    chk(grant_valid == 0, "R8 no grant", int'(grant_valid), 0);
    step();
    chk(flow_err == 0, "R8 single", int'(flow_err), 0);
    chan_cfg[32*2 + 18] = 1'b1;
    step();
    chan_cfg[32*2 + 18] = 1'b0;
    step();
    chk(flow_err == 8'b0000_0100, "R8 rearm", int'(flow_err), 4);
    chan_cfg = '0;
    step();

    // R1: halted channel not granted; R2: global disable blocks grant
    chan_cfg[32*0 +: 32] = mk(1, 1, 0, 0, 0);
    step();
    chk(grant_valid == 0, "R1 halt", int'(grant_valid), 0);
    chan_cfg[32*0 +: 32] = mk(1, 0, 0, 0, 0);
    glb_en = 0;
    step(); step();
    chk(grant_valid == 0, "R2 disabled", int'(grant_valid), 0);
    glb_en = 1;
    step();
    chk(grant_valid == 1 && grant_idx == 0, "R2 enable", int'(grant_idx), 0);
    finish_grant("R7 drop");

    // R3/R4: burst-only request satisfies source line of type 2
    chan_cfg = '0;
    step();
    chan_cfg[32*5 +: 32] = mk(1, 0, 2, 17, 3);
    req_burst = 32'h1 << 17;
    step();
    chk(grant_valid == 1 && grant_idx == 5, "R3 burst src", int'(grant_idx), 5);
    finish_grant("R7 drop");
    req_burst = '0;
    chan_cfg = '0;
    step();

    // R6/R7: hold under new requests, then rescan from 0
    chan_cfg[32*3 +: 32] = mk(1, 0, 0, 0, 0);
    step();
    chk(grant_valid == 1 && grant_idx == 3, "R5 grant", int'(grant_idx), 3);
    chan_cfg[32*1 +: 32] = mk(1, 0, 0, 0, 0);
    step(); step();
    chk(grant_valid == 1 && grant_idx == 3, "R6 hold", int'(grant_idx), 3);
    finish_grant("R7 drop");
    step();
    chk(grant_valid == 1 && grant_idx == 1, "R7 rescan low", int'(grant_idx), 1);
    chan_cfg[32*1 +: 32] = '0;
    finish_grant("R7 drop");
    step();
    chk(grant_valid == 1 && grant_idx == 3, "R7 repeat", int'(grant_idx), 3);
    finish_grant("R7 drop");
    chan_cfg = '0;
    step();

    // R6: stray done in scan cycle is ignored
    chan_cfg[32*0 +: 32] = mk(1, 0, 0, 0, 0);
    xfer_done = 1;
    step();
    xfer_done = 0;
    chk(grant_valid == 1 && grant_idx == 0, "R6 stray done", int'(grant_valid), 1);
    finish_grant("R7 drop");
    chan_cfg = '0;
    step();

    // Random: R4/R5 readiness and priority
    void'($urandom(32'd1234));
    for (int it = 0; it < 400; it++) begin
      logic [NCH*32-1:0] cf;
      logic [31:0] rs, rb;
      int e;
      for (int c = 0; c < NCH; c++) begin
        cf[32*c +: 32] = mk(($urandom % 3) == 0, ($urandom % 5) == 0,
                            (($urandom % 8) == 0) ? 4 + $urandom % 4 : $urandom % 4,
                            $urandom % 32, $urandom % 32);
      end
      rs = $urandom & $urandom;
      rb = $urandom & $urandom;
      glb_en = ($urandom % 8) != 0;
      chan_cfg = cf; req_single = rs; req_burst = rb;
      e = glb_en ? exp_pick(cf, rs | rb) : -1;
      step();
      if (e < 0) begin
        chk(grant_valid == 0, "R4 none ready", int'(grant_valid), 0);
      end else begin
        chk(grant_valid == 1 && int'(grant_idx) == e, "R5 pick", int'(grant_idx), e);
        req_single = $urandom; req_burst = $urandom; glb_en = $urandom % 2;
        step();
        chk(grant_valid == 1 && int'(grant_idx) == e, "R6 hold", int'(grant_idx), e);
        finish_grant("R7 drop");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule